// File: doc/BRIEF.md
# Descriptor Ring Walker

This block owns the hardware side of two descriptor rings, one for receive and one for transmit, kept in a small local descriptor store. Each descriptor holds a 16-bit status/control word, a 16-bit length and a 32-bit buffer address. Software fills descriptors through a host port. It hands a descriptor to the hardware by setting the ownership bit (status bit 15). On the transmit ring this bit means "ready to send". On the receive ring it means "empty, may be filled". Software then writes the wake-up value to the kick input of that ring.

Once woken, a ring engine looks at its current descriptor. If the descriptor is owned, the engine presents the length and address to the frame source (transmit) or presents the buffer address to the frame sink (receive). The engine then waits for a completion pulse, writes the status back and moves on. It returns to index 0 after a descriptor whose wrap bit (status bit 13) is set, or after the last entry of the store. When the engine finds a descriptor it does not own, it stops and drops its active flag. It stays stopped until the next valid kick. Moving the data and running the MAC are left to the neighbouring blocks.

Top module: `bd_ring_walker`

## Requirements
- R1: After reset both rings are inactive, `tx_req` and `rx_buf_valid` are low, and every descriptor reads as zero.
- R2: After a kick, if the current transmit descriptor has status bit 15 set, `tx_req` rises and `tx_len`/`tx_addr` show that descriptor's length and address.
- R3: A `tx_done` pulse while `tx_req` is high makes the engine write the descriptor back with bit 15 cleared, `tx_retries` in bits 5:2 and `tx_fail` in bit 1. Bits 14:6, the length and the address are kept, and the engine moves to the next descriptor.
- R4: After a kick, if the current receive descriptor has bit 15 set, `rx_buf_valid` rises with that descriptor's address on `rx_buf_addr`.
- R5: An `rx_done` pulse while `rx_buf_valid` is high writes `rx_len` (the byte count including the 4-byte CRC) into the length field and clears bit 15. It puts `rx_err` into bits 5:0, keeps bits 14:6 and keeps the address.
- R6: A received length above MAX_FRAME (1518) also sets status bit 5. A length of exactly 1518 does not.
- R7: After the engine writes back a descriptor that has bit 13 set, or the last entry of the store, the next descriptor it examines is index 0.
- R8: When the examined descriptor lacks bit 15, the ring's active flag drops and no request is made. Giving ownership later without a new kick does not wake the ring.
- R9: A kick is acted on only when `kick_data` equals 32'h0100_0000. Any other value leaves the ring idle.
- R10: An `rx_done` pulse while no receive buffer is offered changes no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Write one whole descriptor |
| host_ring | input | 1 | Ring select for host access: 0 receive, 1 transmit |
| host_idx | input | IDX_W | Descriptor index for host access |
| host_wstatus | input | 16 | Status word to write |
| host_wlen | input | 16 | Length to write |
| host_waddr | input | 32 | Buffer address to write |
| host_rstatus | output | 16 | Status word of the selected descriptor |
| host_rlen | output | 16 | Length of the selected descriptor |
| host_raddr | output | 32 | Address of the selected descriptor |
| rx_kick_wr | input | 1 | Write strobe of the receive kick register |
| tx_kick_wr | input | 1 | Write strobe of the transmit kick register |
| kick_data | input | 32 | Value written to a kick register |
| rx_active | output | 1 | Receive engine is walking |
| tx_active | output | 1 | Transmit engine is walking |
| tx_req | output | 1 | Transmit descriptor offered to the frame source |
| tx_len | output | 16 | Length of the offered transmit frame |
| tx_addr | output | 32 | Buffer address of the offered transmit frame |
| tx_done | input | 1 | Transmit completion pulse |
| tx_retries | input | 4 | Retry count for the completed frame |
| tx_fail | input | 1 | Transmission abandoned |
| rx_buf_valid | output | 1 | Receive buffer offered to the frame sink |
| rx_buf_addr | output | 32 | Address of the offered receive buffer |
| rx_done | input | 1 | Receive completion pulse |
| rx_len | input | 16 | Stored byte count including CRC |
| rx_err | input | 6 | Receive error flags |

## Verification
The bench builds the block with DEPTH=4. With this size the store is small enough that a ring can be walked off its last entry, and the return to index 0 can be seen both through the wrap bit (transmit) and through the end of the store (receive). Two transmit descriptors and four receive descriptors reach the stop-on-unowned path, the overlong-frame flag at 1518 and 1600 bytes, and the rejected kick value. In every case the bench reads the written-back descriptors through the host port.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int STAT_W = 16;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 32;
  localparam int OWN_BIT  = 15;
  localparam int WRAP_BIT = 13;
  localparam int LOW_W    = 6;

  typedef struct packed {
    logic [STAT_W-1:0] status;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_OFFER = 2'd2,
    ST_WBACK = 2'd3
  } eng_state_e;
endpackage

// File: rtl/bdr_rst_sync.sv
module bdr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bdr_desc_ram.sv
module bdr_desc_ram
  import bdr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  desc_t            host_d,
  output desc_t            host_q,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  desc_t            eng_d,
  output desc_t            eng_q
);
  desc_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic  hit_host, hit_eng, ent_en;
    desc_t ent_d;

    always_comb begin
      hit_host = host_we && (host_idx == IDX_W'(i));
      hit_eng  = eng_we && (eng_idx == IDX_W'(i));
      ent_en   = hit_host || hit_eng;
      ent_d    = hit_host ? host_d : eng_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (ent_en) mem_q[i] <= ent_d;
    end
  end

  assign host_q = mem_q[host_idx];
  assign eng_q  = mem_q[eng_idx];
endmodule

// File: rtl/bdr_engine.sv
module bdr_engine
  import bdr_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter bit WRITE_LEN = 1'b0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  desc_t            cur_q,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output desc_t            wr_d,
  input  logic             wr_grant,
  output logic             offer_valid,
  input  logic             done,
  input  logic [LOW_W-1:0] done_low,
  input  logic [LEN_W-1:0] done_len,
  output logic             active
);
  eng_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, cap_en;
  logic [LOW_W-1:0] low_q;
  logic [LEN_W-1:0] len_q;
  logic             at_end;

  always_comb begin
    state_d = state_q;
    idx_en  = 1'b0;
    cap_en  = 1'b0;
    wr_en   = 1'b0;
    at_end  = cur_q.status[WRAP_BIT] || (idx_q == IDX_W'(DEPTH - 1));
    idx_d   = at_end ? '0 : idx_q + 1'b1;
    unique case (state_q)
      ST_IDLE:  if (kick) state_d = ST_CHECK;
      ST_CHECK: begin
        if (cur_q.status[OWN_BIT]) state_d = ST_OFFER;
        else if (!kick)            state_d = ST_IDLE;
      end
      ST_OFFER: if (done) begin
        cap_en  = 1'b1;
        state_d = ST_WBACK;
      end
      ST_WBACK: begin
        wr_en = 1'b1;
        if (wr_grant) begin
          idx_en  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wr_d        = cur_q;
    wr_d.status = {1'b0, cur_q.status[STAT_W-2:LOW_W], low_q};
    if (WRITE_LEN) wr_d.len = len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      low_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (cap_en) begin
        low_q <= done_low;
        len_q <= done_len;
      end
    end
  end

  assign idx         = idx_q;
  assign offer_valid = (state_q == ST_OFFER);
  assign active      = (state_q != ST_IDLE);
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker
  import bdr_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          MAX_FRAME  = 1518,
  parameter logic [31:0] KICK_VALUE = 32'h0100_0000,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_ring,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [15:0]       host_wstatus,
  input  logic [15:0]       host_wlen,
  input  logic [31:0]       host_waddr,
  output logic [15:0]       host_rstatus,
  output logic [15:0]       host_rlen,
  output logic [31:0]       host_raddr,
  input  logic              rx_kick_wr,
  input  logic              tx_kick_wr,
  input  logic [31:0]       kick_data,
  output logic              rx_active,
  output logic              tx_active,
  output logic              tx_req,
  output logic [15:0]       tx_len,
  output logic [31:0]       tx_addr,
  input  logic              tx_done,
  input  logic [3:0]        tx_retries,
  input  logic              tx_fail,
  output logic              rx_buf_valid,
  output logic [31:0]       rx_buf_addr,
  input  logic              rx_done,
  input  logic [15:0]       rx_len,
  input  logic [5:0]        rx_err
);
  localparam int NRING = 2;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_FRAME);

  logic rst_sync_n;
  bdr_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  logic             kick_ok;
  logic             kick  [NRING];
  logic             done  [NRING];
  logic [LOW_W-1:0] low   [NRING];
  logic [LEN_W-1:0] dlen  [NRING];
  logic             offer [NRING];
  logic             act   [NRING];
  desc_t            eng_q [NRING];
  desc_t            host_q[NRING];
  desc_t            host_d;

  assign kick_ok = (kick_data == KICK_VALUE);
  assign host_d  = '{status: host_wstatus, len: host_wlen, addr: host_waddr};

  always_comb begin
    kick[0] = rx_kick_wr && kick_ok;
    kick[1] = tx_kick_wr && kick_ok;
    done[0] = rx_done;
    done[1] = tx_done;
    low[0]  = rx_err | ((rx_len > MAX_LEN) ? 6'h20 : 6'h00);
    low[1]  = {tx_retries, tx_fail, 1'b0};
    dlen[0] = rx_len;
    dlen[1] = '0;
  end

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    logic             h_we, e_we;
    logic [IDX_W-1:0] e_idx;
    desc_t            e_d;

    assign h_we = host_wr && (host_ring == g[0]);

    bdr_desc_ram #(.DEPTH(DEPTH)) u_ram (
      .clk(clk), .rst_n(rst_sync_n),
      .host_we(h_we), .host_idx(host_idx), .host_d(host_d), .host_q(host_q[g]),
      .eng_we(e_we && !h_we), .eng_idx(e_idx), .eng_d(e_d), .eng_q(eng_q[g])
    );

    bdr_engine #(.DEPTH(DEPTH), .WRITE_LEN(g == 0)) u_eng (
      .clk(clk), .rst_n(rst_sync_n), .kick(kick[g]), .cur_q(eng_q[g]),
      .idx(e_idx), .wr_en(e_we), .wr_d(e_d), .wr_grant(!h_we),
      .offer_valid(offer[g]), .done(done[g]), .done_low(low[g]),
      .done_len(dlen[g]), .active(act[g])
    );
  end

  always_comb begin
    host_rstatus = host_q[host_ring].status;
    host_rlen    = host_q[host_ring].len;
    host_raddr   = host_q[host_ring].addr;
  end

  assign rx_active    = act[0];
  assign tx_active    = act[1];
  assign rx_buf_valid = offer[0];
  assign rx_buf_addr  = eng_q[0].addr;
  assign tx_req       = offer[1];
  assign tx_len       = eng_q[1].len;
  assign tx_addr      = eng_q[1].addr;
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
  parameter logic [31:0] KICK_VALUE = 32'h0100_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_kick_wr,
  input logic        rx_kick_wr,
  input logic [31:0] kick_data,
  input logic        tx_active,
  input logic        rx_active,
  input logic        tx_req,
  input logic        tx_done,
  input logic        rx_buf_valid,
  input logic        rx_done
);
  // R2: a transmit offer only exists while the ring is walking
  a_r2_req_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_active);

  // R4: a receive offer only exists while the ring is walking
  a_r4_buf_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    rx_buf_valid |-> rx_active);

  // R3: completion withdraws the transmit offer
  a_r3_req_drops_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done) |=> !tx_req);

  // R5: completion withdraws the receive offer
  a_r5_buf_drops_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf_valid && rx_done) |=> !rx_buf_valid);

  // R9: the wake value starts an idle ring
  a_r9_kick_wakes_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kick_wr && kick_data == KICK_VALUE && !tx_active) |=> tx_active);

  // R9: any other value leaves an idle ring idle
  a_r9_bad_kick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kick_wr && kick_data != KICK_VALUE && !tx_active) |=> !tx_active);
endmodule

bind bd_ring_walker bdr_checker #(.KICK_VALUE(KICK_VALUE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_kick_wr(tx_kick_wr), .rx_kick_wr(rx_kick_wr),
  .kick_data(kick_data), .tx_active(tx_active), .rx_active(rx_active),
  .tx_req(tx_req), .tx_done(tx_done), .rx_buf_valid(rx_buf_valid), .rx_done(rx_done)
);

// File: tb/tb_bd_ring_walker.sv
module tb_bd_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam logic [31:0] KICK = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic host_wr, host_ring;
  logic [1:0] host_idx;
  logic [15:0] host_wstatus, host_wlen, host_rstatus, host_rlen;
  logic [31:0] host_waddr, host_raddr;
  logic rx_kick_wr, tx_kick_wr;
  logic [31:0] kick_data;
  logic rx_active, tx_active, tx_req, tx_done, tx_fail, rx_buf_valid, rx_done;
  logic [15:0] tx_len, rx_len;
  logic [31:0] tx_addr, rx_buf_addr;
  logic [3:0] tx_retries;
  logic [5:0] rx_err;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bd_ring_walker #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_desc(input logic ring, input int idx, input logic [15:0] st,
                         input logic [15:0] ln, input logic [31:0] ad);
    @(negedge clk);
    host_wr = 1'b1; host_ring = ring; host_idx = 2'(idx);
    host_wstatus = st; host_wlen = ln; host_waddr = ad;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_desc(input logic ring, input int idx, input string req,
                         input logic [15:0] st, input logic [15:0] ln, input logic [31:0] ad);
    host_ring = ring; host_idx = 2'(idx);
    #1;
    chk({req, " status"}, 32'(host_rstatus), 32'(st));
    chk({req, " length"}, 32'(host_rlen), 32'(ln));
    chk({req, " address"}, host_raddr, ad);
  endtask

  task automatic kick(input logic tx, input logic [31:0] v);
    @(negedge clk);
    tx_kick_wr = tx; rx_kick_wr = !tx; kick_data = v;
    @(negedge clk);
    tx_kick_wr = 1'b0; rx_kick_wr = 1'b0; kick_data = '0;
  endtask

  task automatic wait_tx;
    for (int i = 0; i < 20; i++) begin
      if (tx_req) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_rx;
    for (int i = 0; i < 20; i++) begin
      if (rx_buf_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic tx_complete(input logic [3:0] r, input logic f);
    tx_done = 1'b1; tx_retries = r; tx_fail = f;
    @(negedge clk);
    tx_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_complete(input logic [15:0] l, input logic [5:0] e);
    rx_done = 1'b1; rx_len = l; rx_err = e;
    @(negedge clk);
    rx_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 tx_active", 32'(tx_active), 0);
    chk("R1 rx_active", 32'(rx_active), 0);
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 rx_buf_valid", 32'(rx_buf_valid), 0);
    rd_desc(1'b1, 2, "R1 tx desc2", 16'h0, 16'h0, 32'h0);
  endtask

  task automatic t_tx;
    wr_desc(1'b1, 0, 16'h8800, 16'd100, 32'h1000);
    wr_desc(1'b1, 1, 16'hA000, 16'd200, 32'h2000);
    wr_desc(1'b1, 2, 16'h8000, 16'd300, 32'h3000);
    kick(1'b1, 32'h0000_0001);
    repeat (4) @(negedge clk);
    chk("R9 bad kick tx_active", 32'(tx_active), 0);
    chk("R9 bad kick tx_req", 32'(tx_req), 0);
    kick(1'b1, KICK);
    wait_tx;
    chk("R2 tx_req", 32'(tx_req), 1);
    chk("R2 tx_len", 32'(tx_len), 100);
    chk("R2 tx_addr", tx_addr, 32'h1000);
    tx_complete(4'd5, 1'b1);
    rd_desc(1'b1, 0, "R3 tx desc0", 16'h0816, 16'd100, 32'h1000);
    wait_tx;
    chk("R3 next tx_addr", tx_addr, 32'h2000);
    tx_complete(4'd0, 1'b0);
    rd_desc(1'b1, 1, "R3 tx desc1", 16'h2000, 16'd200, 32'h2000);
    chk("R8 tx stops", 32'(tx_active), 0);
    rd_desc(1'b1, 2, "R7 tx desc2 skipped", 16'h8000, 16'd300, 32'h3000);
    wr_desc(1'b1, 0, 16'h8000, 16'd64, 32'h1800);
    repeat (4) @(negedge clk);
    chk("R8 no wake without kick", 32'(tx_req), 0);
    kick(1'b1, KICK);
    wait_tx;
    chk("R7 wrap to base tx_addr", tx_addr, 32'h1800);
    tx_complete(4'd1, 1'b0);
  endtask

  task automatic t_rx;
    for (int i = 0; i < DEPTH; i++)
      wr_desc(1'b0, i, 16'h8000, 16'd0, 32'h4000 + 32'(i) * 32'h1000);
    rx_done = 1'b1; rx_len = 16'd64; rx_err = 6'h3;
    @(negedge clk);
    rx_done = 1'b0;
    repeat (3) @(negedge clk);
    rd_desc(1'b0, 0, "R10 stray done", 16'h8000, 16'd0, 32'h4000);
    kick(1'b0, KICK);
    wait_rx;
    chk("R4 rx_buf_valid", 32'(rx_buf_valid), 1);
    chk("R4 rx_buf_addr", rx_buf_addr, 32'h4000);
    rx_complete(16'd68, 6'h0);
    rd_desc(1'b0, 0, "R5 rx desc0", 16'h0000, 16'd68, 32'h4000);
    wait_rx;
    chk("R4 rx next addr", rx_buf_addr, 32'h5000);
    rx_complete(16'd1600, 6'h01);
    rd_desc(1'b0, 1, "R6 overlong", 16'h0021, 16'd1600, 32'h5000);
    wait_rx;
    rx_complete(16'd1518, 6'h00);
    rd_desc(1'b0, 2, "R6 max length", 16'h0000, 16'd1518, 32'h6000);
    wait_rx;
    chk("R4 rx last addr", rx_buf_addr, 32'h7000);
    rx_complete(16'd70, 6'h04);
    rd_desc(1'b0, 3, "R5 rx desc3", 16'h0004, 16'd70, 32'h7000);
    chk("R8 rx stops", 32'(rx_active), 0);
    wr_desc(1'b0, 0, 16'h8000, 16'd0, 32'h4400);
    kick(1'b0, KICK);
    wait_rx;
    chk("R7 rx end of store to base", rx_buf_addr, 32'h4400);
  endtask

  initial begin
    rst_n = 1'b0;
    host_wr = 0; host_ring = 0; host_idx = 0; host_wstatus = 0; host_wlen = 0; host_waddr = 0;
    rx_kick_wr = 0; tx_kick_wr = 0; kick_data = 0;
    tx_done = 0; tx_retries = 0; tx_fail = 0; rx_done = 0; rx_len = 0; rx_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_tx;
    t_rx;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule